// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block forms 20-bit physical addresses for a 16-bit processor core that works with four 16-bit segment registers. Each request carries an access kind and a 16-bit offset. The block picks one segment register, shifts it left by four bit positions and adds the offset. Any carry above the top address bit is dropped, so the result always stays inside a 1 MiB space. A code fetch always uses the code segment. A stack access always uses the stack segment. A data access uses the data segment unless the request carries a valid segment override.

The block also holds the stack pointer. A word push first lowers the pointer by two and then addresses the new top of stack. A word pop addresses the current top and then raises the pointer by two. The pointer wraps within 64 KiB. Instruction decode loads the segment registers and the stack pointer through dedicated write ports. The address comes out of a register one cycle after the request strobe, and the stack-pointer update lands on that same clock edge.

Top module: `agen_realmode`

## Requirements
- R1: For a served request, `phys_addr` equals (segment × 16 + offset) modulo 2^20. For example, segment A000h with offset 5677h and segment A111h with offset 4567h both give A5677h.
- R2: A carry out of address bit 19 is discarded. Segment FFFFh with offset 0010h gives 00000h, and FFFFh with FFFFh gives 0FFEFh.
- R3: `req_op` encodes the access as 0 = code fetch, 1 = data, 2 = stack with explicit offset, 3 = push, 4 = pop. Without an override, op 0 uses the code segment, op 1 uses the data segment, and ops 2 to 4 use the stack segment.
- R4: With `ovr_valid` = 1 on a data access, `ovr_sel` chooses the segment. The encoding is 00 = extra, 01 = code, 10 = stack, 11 = data.
- R5: An override presented with ops 0, 2, 3 or 4 is ignored, and the default segment of that op is used.
- R6: A push (op 3) returns the address stack segment:(SP − 2). On the same edge, SP becomes SP − 2.
- R7: A pop (op 4) returns the address stack segment:SP. On the same edge, SP becomes SP + 2.
- R8: SP wraps modulo 2^16. A push from 0000h gives FFFEh, and a pop from FFFEh gives 0000h.
- R9: `addr_valid` is high for exactly the one cycle after each strobe that carries a legal op. When no request is served, `phys_addr` holds its last value.
- R10: `seg_wr_sel` uses the R4 encoding. A written value is used by requests from the next cycle onward. A request in the same cycle as the write still uses the old value.
- R11: `sp_wr_en` loads SP from `sp_wr_data`. When it coincides with a push or pop, the load wins the pointer update, while the address is still formed from the old SP.
- R12: After reset, all segment registers, SP and `phys_addr` are zero and `addr_valid` is low. A strobe with an op code of 5 to 7 serves nothing: `addr_valid` stays low, and `phys_addr` and SP do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Access kind (R3 encoding) |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment (R4 encoding) |
| offset | input | 16 | Offset for ops 0 to 2 |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | Segment write value |
| sp_wr_en | input | 1 | Stack-pointer load strobe |
| sp_wr_data | input | 16 | Stack-pointer load value |
| addr_valid | output | 1 | Address valid, one cycle after the strobe |
| phys_addr | output | 20 | Registered physical address |
| stk_ptr | output | 16 | Current stack pointer |

## Verification
Both the address and the stack-pointer change are due on the first rising edge after a strobe. The bench drives every input on a falling edge and reads `addr_valid`, `phys_addr` and `stk_ptr` on the next falling edge, half a cycle after the results are registered. Segment and pointer writes made together with a request are checked in that same sampling slot for the old-value address, and again on the following request for the new value. Checks on ignored strobes look one falling edge later, confirming that valid stays low and that the address and pointer are unchanged.

// File: rtl/agen_pkg.sv
package agen_pkg;

   localparam int NUM_SEGS = 4;

   // Segment register index; shared by override field and write port
   typedef enum logic [1:0] {
      SEG_EXTRA = 2'b00,
      SEG_CODE  = 2'b01,
      SEG_STACK = 2'b10,
      SEG_DATA  = 2'b11
   } seg_idx_e;

   typedef enum logic [2:0] {
      OP_FETCH = 3'd0,
      OP_DATA  = 3'd1,
      OP_STACK = 3'd2,
      OP_PUSH  = 3'd3,
      OP_POP   = 3'd4
   } acc_op_e;

   function automatic logic op_is_legal(input logic [2:0] op);
      return op <= 3'd4;
   endfunction

endpackage

// File: rtl/agen_segfile.sv
module agen_segfile
   import agen_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en_i,
   input  logic [1:0]                         wr_sel_i,
   input  logic [SEG_W-1:0]                   wr_data_i,
   output logic [NUM_SEGS-1:0][SEG_W-1:0]     seg_vals_o
);

   generate
      if (SEG_W < 1) begin : g_bad_width
         $error("agen_segfile: SEG_W must be positive");
      end
   endgenerate

   logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;

   for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            seg_q[g] <= '0;
         end else if (wr_en_i && (wr_sel_i == 2'(g))) begin
            seg_q[g] <= wr_data_i;
         end
      end
   end

   assign seg_vals_o = seg_q;

   // R10: a written register holds the written value on the next cycle
   p_seg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> seg_q[$past(wr_sel_i)] == $past(wr_data_i));

endmodule

// File: rtl/agen_segsel.sv
module agen_segsel
   import agen_pkg::*;
(
   input  logic [2:0] op_i,
   input  logic       ovr_valid_i,
   input  logic [1:0] ovr_sel_i,
   output seg_idx_e   seg_o
);

   always_comb begin
      unique case (op_i)
         OP_FETCH: seg_o = SEG_CODE;
         OP_DATA:  seg_o = ovr_valid_i ? seg_idx_e'(ovr_sel_i) : SEG_DATA;
         default:  seg_o = SEG_STACK;
      endcase
   end

   // R5: non-data ops never pick the extra segment, whatever the override
   always_comb begin
      if (op_i != OP_DATA) begin
         p_no_ovr_on_other_r5: assert (seg_o != SEG_EXTRA);
      end
   end

endmodule

// File: rtl/agen_stkptr.sv
module agen_stkptr #(
   parameter int W    = 16,
   parameter int STEP = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] sp_o,
   output logic [W-1:0] stk_off_o
);

   localparam logic [W-1:0] STEP_W = W'(STEP);

   generate
      if (STEP < 1 || W < 2) begin : g_bad_step
         $error("agen_stkptr: STEP must be positive and W at least 2");
      end
   endgenerate

   logic [W-1:0] sp_q;
   logic [W-1:0] sp_dec;
   logic [W-1:0] sp_inc;

   assign sp_dec = sp_q - STEP_W;
   assign sp_inc = sp_q + STEP_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (wr_en_i) begin
         sp_q <= wr_data_i;
      end else if (push_i) begin
         sp_q <= sp_dec;
      end else if (pop_i) begin
         sp_q <= sp_inc;
      end
   end

   // Push addresses the slot below; pop addresses the current top
   assign stk_off_o = push_i ? sp_dec : sp_q;
   assign sp_o      = sp_q;

   p_push_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !wr_en_i) |=> sp_q == $past(sp_q) - STEP_W);

   p_pop_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !wr_en_i) |=> sp_q == $past(sp_q) + STEP_W);

   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> sp_q == $past(wr_data_i));

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_i && !pop_i && !wr_en_i) |=> $stable(sp_q));

endmodule

// File: rtl/agen_addsum.sv
module agen_addsum #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0]  seg_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [ADDR_W-1:0] addr_o
);

   generate
      if (ADDR_W != SEG_W + SHIFT || OFF_W - SHIFT > SEG_W || OFF_W <= SHIFT) begin : g_bad_cfg
         $error("agen_addsum: inconsistent width configuration");
      end

      if (SHIFT == 0) begin : g_flat
         // No shift: plain modular sum
         assign addr_o = seg_i + ADDR_W'(off_i);
      end else begin : g_split
         // Low bits of the offset pass straight through; only the upper
         // part needs an adder, SEG_W bits wide, carry out dropped
         localparam int HI_W = OFF_W - SHIFT;
         logic [HI_W-1:0]  off_hi;
         logic [SEG_W-1:0] upper;
         assign off_hi              = off_i[OFF_W-1:SHIFT];
         assign upper               = seg_i + SEG_W'(off_hi);
         assign addr_o[SHIFT-1:0]   = off_i[SHIFT-1:0];
         assign addr_o[ADDR_W-1:SHIFT] = upper;
      end
   endgenerate

endmodule

// File: rtl/agen_realmode.sv
module agen_realmode
   import agen_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int OFF_W     = 16,
   parameter int SHIFT     = 4,
   parameter int PUSH_STEP = 2,
   localparam int ADDR_W   = SEG_W + SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic              ovr_valid,
   input  logic [1:0]        ovr_sel,
   input  logic [OFF_W-1:0]  offset,
   input  logic              seg_wr_en,
   input  logic [1:0]        seg_wr_sel,
   input  logic [SEG_W-1:0]  seg_wr_data,
   input  logic              sp_wr_en,
   input  logic [OFF_W-1:0]  sp_wr_data,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] phys_addr,
   output logic [OFF_W-1:0]  stk_ptr
);

   logic                           served;
   logic                           do_push;
   logic                           do_pop;
   logic [NUM_SEGS-1:0][SEG_W-1:0] seg_vals;
   seg_idx_e                       seg_pick;
   logic [OFF_W-1:0]               stk_off;
   logic [OFF_W-1:0]               eff_off;
   logic [ADDR_W-1:0]              addr_next;
   logic                           valid_q;
   logic [ADDR_W-1:0]              addr_q;

   assign served  = req_valid && op_is_legal(req_op);
   assign do_push = served && (req_op == OP_PUSH);
   assign do_pop  = served && (req_op == OP_POP);

   agen_segfile #(.SEG_W(SEG_W)) u_segfile (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (seg_wr_en),
      .wr_sel_i   (seg_wr_sel),
      .wr_data_i  (seg_wr_data),
      .seg_vals_o (seg_vals)
   );

   agen_segsel u_segsel (
      .op_i        (req_op),
      .ovr_valid_i (ovr_valid),
      .ovr_sel_i   (ovr_sel),
      .seg_o       (seg_pick)
   );

   agen_stkptr #(.W(OFF_W), .STEP(PUSH_STEP)) u_stkptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (do_push),
      .pop_i     (do_pop),
      .wr_en_i   (sp_wr_en),
      .wr_data_i (sp_wr_data),
      .sp_o      (stk_ptr),
      .stk_off_o (stk_off)
   );

   assign eff_off = (req_op == OP_PUSH || req_op == OP_POP) ? stk_off : offset;

   agen_addsum #(
      .SEG_W  (SEG_W),
      .OFF_W  (OFF_W),
      .SHIFT  (SHIFT),
      .ADDR_W (ADDR_W)
   ) u_addsum (
      .seg_i  (seg_vals[seg_pick]),
      .off_i  (eff_off),
      .addr_o (addr_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
      end else begin
         valid_q <= served;
         if (served) begin
            addr_q <= addr_next;
         end
      end
   end

   assign addr_valid = valid_q;
   assign phys_addr  = addr_q;

   // R9: no strobe, no valid on the next cycle; address held
   p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!addr_valid && $stable(phys_addr)));

   // R1: a code fetch keeps the offset's low nibble in the address
   p_fetch_low_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_FETCH) |=>
         (addr_valid && phys_addr[SHIFT-1:0] == $past(offset[SHIFT-1:0])));

   // R12: illegal op codes are not served
   p_illegal_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op > 3'd4) |=> (!addr_valid && $stable(phys_addr)));

endmodule

// File: tb/tb_agen_realmode.sv
module tb_agen_realmode;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = 3'd0;
   logic        ovr_valid = 1'b0;
   logic [1:0]  ovr_sel = 2'd0;
   logic [15:0] offset = 16'd0;
   logic        seg_wr_en = 1'b0;
   logic [1:0]  seg_wr_sel = 2'd0;
   logic [15:0] seg_wr_data = 16'd0;
   logic        sp_wr_en = 1'b0;
   logic [15:0] sp_wr_data = 16'd0;
   logic        addr_valid;
   logic [19:0] phys_addr;
   logic [15:0] stk_ptr;

   int checks = 0;
   int fails  = 0;

   // Bench model, indexed by the R4 encoding
   logic [15:0] m_seg [4];
   logic [15:0] m_sp;
   logic [19:0] m_addr;

   always #10 clk = ~clk;

   agen_realmode dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_op      (req_op),
      .ovr_valid   (ovr_valid),
      .ovr_sel     (ovr_sel),
      .offset      (offset),
      .seg_wr_en   (seg_wr_en),
      .seg_wr_sel  (seg_wr_sel),
      .seg_wr_data (seg_wr_data),
      .sp_wr_en    (sp_wr_en),
      .sp_wr_data  (sp_wr_data),
      .addr_valid  (addr_valid),
      .phys_addr   (phys_addr),
      .stk_ptr     (stk_ptr)
   );

   function automatic logic [19:0] calc(input logic [15:0] s, input logic [15:0] o);
      int unsigned t;
      t = (int'(s) * 16 + int'(o)) % 1048576;
      return 20'(t);
   endfunction

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_seg(input int sel, input logic [15:0] val);
      @(negedge clk);
      seg_wr_en   = 1'b1;
      seg_wr_sel  = 2'(sel);
      seg_wr_data = val;
      @(negedge clk);
      seg_wr_en = 1'b0;
      m_seg[sel] = val;
   endtask

   task automatic wr_sp(input logic [15:0] val);
      @(negedge clk);
      sp_wr_en   = 1'b1;
      sp_wr_data = val;
      @(negedge clk);
      sp_wr_en = 1'b0;
      m_sp = val;
      check(stk_ptr == val, "R11 load", 32'(stk_ptr), 32'(val));
   endtask

   // Expected segment per R3/R4/R5
   function automatic logic [15:0] pick(input int op, input int ov, input int sel);
      if (op == 1 && ov != 0) return m_seg[sel];
      if (op == 0) return m_seg[1];
      if (op == 1) return m_seg[3];
      return m_seg[2];
   endfunction

   task automatic do_req(input int op, input int ov, input int sel,
                         input logic [15:0] off, input string req);
      logic [15:0] o;
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = 3'(op);
      ovr_valid = ov[0];
      ovr_sel   = 2'(sel);
      offset    = off;
      if (op == 3) begin
         m_sp = m_sp - 16'd2;
         o = m_sp;
      end else if (op == 4) begin
         o = m_sp;
         m_sp = m_sp + 16'd2;
      end else begin
         o = off;
      end
      m_addr = calc(pick(op, ov, sel), o);
      @(negedge clk);
      req_valid = 1'b0;
      ovr_valid = 1'b0;
      check(addr_valid == 1'b1, req, 32'(addr_valid), 32'd1);
      check(phys_addr == m_addr, req, 32'(phys_addr), 32'(m_addr));
      check(stk_ptr == m_sp, req, 32'(stk_ptr), 32'(m_sp));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      for (int k = 0; k < 4; k++) m_seg[k] = 16'h0000;
      m_sp = 16'h0000;
      m_addr = 20'h0;
      repeat (3) @(negedge clk);
      // R12 reset state
      check(addr_valid == 1'b0, "R12 reset valid", 32'(addr_valid), 32'd0);
      check(phys_addr == 20'h0, "R12 reset addr", 32'(phys_addr), 32'd0);
      check(stk_ptr == 16'h0, "R12 reset sp", 32'(stk_ptr), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 segments reset to zero
      do_req(0, 0, 0, 16'h1234, "R12 reset code segment zero");

      // R1 worked examples
      wr_seg(1, 16'hA000);
      wr_seg(3, 16'hA111);
      do_req(0, 0, 0, 16'h5677, "R1 A000:5677");
      check(phys_addr == 20'hA5677, "R1 literal", 32'(phys_addr), 32'hA5677);
      do_req(1, 0, 0, 16'h4567, "R1 A111:4567");
      check(phys_addr == 20'hA5677, "R1 alias literal", 32'(phys_addr), 32'hA5677);

      // R1 sweep through the extra segment selected by override
      for (int i = 0; i < 64; i++) begin
         wr_seg(0, 16'(i * 1031 + 7));
         for (int j = 0; j < 16; j++) begin
            do_req(1, 1, 0, 16'(j * 4099 + i), "R1 sweep");
         end
      end

      // R2 wrap of the address space
      wr_seg(0, 16'hFFFF);
      do_req(1, 1, 0, 16'h0010, "R2 wrap");
      check(phys_addr == 20'h00000, "R2 literal 0", 32'(phys_addr), 32'h0);
      do_req(1, 1, 0, 16'hFFFF, "R2 wrap max");
      check(phys_addr == 20'h0FFEF, "R2 literal FFEF", 32'(phys_addr), 32'h0FFEF);

      // R3/R4/R5 matrix: every op, override on/off, every selector
      wr_seg(0, 16'h1E00);
      wr_seg(1, 16'h2C00);
      wr_seg(2, 16'h3500);
      wr_seg(3, 16'h4700);
      wr_sp(16'h0100);
      for (int op = 0; op < 5; op++) begin
         for (int ov = 0; ov < 2; ov++) begin
            for (int s = 0; s < 4; s++) begin
               if (op == 1 && ov == 1) do_req(op, ov, s, 16'h0ABC, "R4 override");
               else if (ov == 1)       do_req(op, ov, s, 16'h0ABC, "R5 override ignored");
               else                    do_req(op, ov, s, 16'h0ABC, "R3 default segment");
            end
         end
      end

      // R6/R7 push then pop
      wr_sp(16'h0100);
      do_req(3, 0, 0, 16'h0000, "R6 push");
      check(phys_addr == calc(16'h3500, 16'h00FE), "R6 push addr", 32'(phys_addr),
            32'(calc(16'h3500, 16'h00FE)));
      check(stk_ptr == 16'h00FE, "R6 push sp", 32'(stk_ptr), 32'h00FE);
      do_req(4, 0, 0, 16'h0000, "R7 pop");
      check(phys_addr == calc(16'h3500, 16'h00FE), "R7 pop addr", 32'(phys_addr),
            32'(calc(16'h3500, 16'h00FE)));
      check(stk_ptr == 16'h0100, "R7 pop sp", 32'(stk_ptr), 32'h0100);

      // R8 pointer wrap
      wr_sp(16'h0000);
      do_req(3, 0, 0, 16'h0000, "R8 push wrap");
      check(stk_ptr == 16'hFFFE, "R8 push wrap sp", 32'(stk_ptr), 32'hFFFE);
      do_req(4, 0, 0, 16'h0000, "R8 pop wrap");
      check(stk_ptr == 16'h0000, "R8 pop wrap sp", 32'(stk_ptr), 32'h0000);

      // R9 single-cycle valid, address held
      do_req(2, 0, 0, 16'h0042, "R9 request");
      @(negedge clk);
      check(addr_valid == 1'b0, "R9 valid one cycle", 32'(addr_valid), 32'd0);
      check(phys_addr == m_addr, "R9 addr held", 32'(phys_addr), 32'(m_addr));

      // R10 write in the same cycle as a request
      @(negedge clk);
      seg_wr_en = 1'b1; seg_wr_sel = 2'b11; seg_wr_data = 16'h5000;
      req_valid = 1'b1; req_op = 3'd1; ovr_valid = 1'b0; offset = 16'h0003;
      @(negedge clk);
      seg_wr_en = 1'b0; req_valid = 1'b0;
      check(phys_addr == calc(16'h4700, 16'h0003), "R10 old value used",
            32'(phys_addr), 32'(calc(16'h4700, 16'h0003)));
      m_seg[3] = 16'h5000;
      do_req(1, 0, 0, 16'h0003, "R10 new value next request");

      // R11 load together with push
      wr_sp(16'h0200);
      @(negedge clk);
      sp_wr_en = 1'b1; sp_wr_data = 16'h4000;
      req_valid = 1'b1; req_op = 3'd3;
      @(negedge clk);
      sp_wr_en = 1'b0; req_valid = 1'b0;
      check(phys_addr == calc(16'h3500, 16'h01FE), "R11 addr from old sp",
            32'(phys_addr), 32'(calc(16'h3500, 16'h01FE)));
      check(stk_ptr == 16'h4000, "R11 load wins", 32'(stk_ptr), 32'h4000);
      m_sp = 16'h4000;
      m_addr = phys_addr;

      // R12 illegal op codes ignored
      for (int op = 5; op < 8; op++) begin
         @(negedge clk);
         req_valid = 1'b1; req_op = 3'(op); offset = 16'h7777;
         @(negedge clk);
         req_valid = 1'b0;
         check(addr_valid == 1'b0, "R12 illegal no valid", 32'(addr_valid), 32'd0);
         check(phys_addr == m_addr, "R12 illegal addr held", 32'(phys_addr), 32'(m_addr));
         check(stk_ptr == m_sp, "R12 illegal sp held", 32'(stk_ptr), 32'(m_sp));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule